// File: doc/BRIEF.md
# Master-Clocked Serial Result Output Controller

This block sends a 16-bit conversion result to a host over a three-wire serial link. The block generates the link's clock itself. It asks a conversion engine to start a conversion, receives the result word with a one-cycle done pulse, and shifts the word out most significant bit first. A framing signal is active for exactly the span in which the data line carries valid bits. A BUSY output tells the host when a conversion, or a transfer tied to one, is still in progress.

The read mode is sampled when a request is accepted, and there are two. In read-after mode, the frame starts as soon as the new result arrives, and BUSY is held high until the last bit has left. In read-during mode, the frame starts at the request and carries the result of the previous conversion while the new one runs, and BUSY covers only the conversion. A divide input halves the serial clock rate for slow hosts. Separate inputs invert the serial clock and the framing signal.

Top module: `mser_out_ctrl`

## Requirements
- R1: Each frame carries the 16-bit word most significant bit first, with exactly 16 rising edges of the uninverted serial clock while the frame is active.
- R2: `sync_o` equals frame-active XOR `sync_inv_i`. The frame is active from the first bit until the end of the 16th bit period.
- R3: The uninverted serial clock is low whenever no frame is active, and `sclk_o` equals that clock XOR `sclk_inv_i`. The idle level is therefore `sclk_inv_i`.
- R4: In read-after mode (`read_during_i` = 0 at the request), `conv_start_o` pulses for one cycle, one cycle after the request. The frame starts one cycle after `conv_done_i` and carries `conv_word_i`. `busy_o` stays high through the whole frame and falls on the same clock edge on which the frame ends.
- R5: A bit period lasts 4 system cycles when `slow_sclk_i` = 0 and 8 when it is 1, so rising serial clock edges are that far apart. `slow_sclk_i` is sampled when the frame starts. Within a bit, the uninverted clock is low for the first quarter, high for the middle half and low for the last quarter.
- R6: Each bit on `sdout_o` is held unchanged across both the rising and the falling serial clock edge of its period.
- R7: A request that arrives while `busy_o` is high, or while a frame is still being sent, is ignored: no `conv_start_o` pulse follows it.
- R8: In read-during mode (`read_during_i` = 1 at the request), the frame starts one cycle after the request and carries the most recent earlier result, which is zero after reset. `busy_o` falls one cycle after `conv_done_i`, even while the frame is still running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| cnv_req_i | input | 1 | Conversion request strobe from the host |
| read_during_i | input | 1 | 0: read after conversion, 1: read previous result during conversion |
| slow_sclk_i | input | 1 | 1 doubles the serial bit period |
| sclk_inv_i | input | 1 | Inverts the serial clock output |
| sync_inv_i | input | 1 | Inverts the framing output |
| conv_start_o | output | 1 | One-cycle start pulse to the conversion engine |
| conv_done_i | input | 1 | One-cycle done pulse from the conversion engine |
| conv_word_i | input | 16 | Result word, valid with `conv_done_i` |
| busy_o | output | 1 | Conversion or tied transfer in progress |
| sclk_o | output | 1 | Serial clock |
| sync_o | output | 1 | Frame marker |
| sdout_o | output | 1 | Serial data, MSB first |

## Verification
Every output is registered, so each result is due a fixed number of edges after its cause. The start pulse follows a request by one cycle. The frame follows `conv_done_i` (read-after) or the request (read-during) by one cycle. BUSY falls one cycle after done (read-during) or on the edge that closes the frame (read-after). The bench drives and samples on the falling system clock edge, so every registered change is settled when it looks. It rebuilds the word from the data line at each rising serial clock edge inside the frame, compares the data at the matching falling edge, and measures the spacing between rising edges in system cycles. The sweep covers both modes, both clock rates and all four polarity settings, with all-ones and alternating end-bit words among the data.

// File: rtl/mser_pkg.sv
package mser_pkg;
    typedef enum logic {
        RD_AFTER  = 1'b0,
        RD_DURING = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/mser_bit_timer.sv
// Paces one bit period: low quarter, high half, low quarter.
module mser_bit_timer #(
    parameter int QUART_FAST = 1,
    parameter int QUART_SLOW = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic run_i,
    input  logic slow_i,
    output logic sclk_raw_o,
    output logic bit_end_o
);
    localparam int CYC_W = $clog2(4 * QUART_SLOW);
    localparam logic [CYC_W-1:0] LAST_F = CYC_W'(4 * QUART_FAST - 1);
    localparam logic [CYC_W-1:0] LAST_S = CYC_W'(4 * QUART_SLOW - 1);
    localparam logic [CYC_W-1:0] RISE_F = CYC_W'(QUART_FAST);
    localparam logic [CYC_W-1:0] RISE_S = CYC_W'(QUART_SLOW);
    localparam logic [CYC_W-1:0] FALL_F = CYC_W'(3 * QUART_FAST);
    localparam logic [CYC_W-1:0] FALL_S = CYC_W'(3 * QUART_SLOW);

    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic             slow;
        logic             sclk;
    } tmr_t;

    tmr_t             st_d, st_q;
    logic [CYC_W-1:0] last_c, rise_c, fall_c, ncyc;

    always_comb begin
        last_c    = st_q.slow ? LAST_S : LAST_F;
        rise_c    = st_q.slow ? RISE_S : RISE_F;
        fall_c    = st_q.slow ? FALL_S : FALL_F;
        bit_end_o = run_i && (st_q.cyc == last_c);
        ncyc      = bit_end_o ? '0 : st_q.cyc + 1'b1;
        st_d      = st_q;
        if (load_i) begin
            st_d.cyc  = '0;
            st_d.slow = slow_i;
            st_d.sclk = 1'b0;
        end else if (run_i) begin
            st_d.cyc  = ncyc;
            st_d.sclk = (ncyc >= rise_c) && (ncyc < fall_c);
        end else begin
            st_d.cyc  = '0;
            st_d.sclk = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sclk_raw_o = st_q.sclk;
endmodule

// File: rtl/mser_shifter.sv
// Holds the outgoing word and counts the bits already sent.
module mser_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              step_i,
    output logic              msb_o,
    output logic              last_o
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sh  = word_i;
            st_d.cnt = '0;
        end else if (step_i) begin
            if (st_q.cnt == LAST_BIT) begin
                st_d.sh  = '0;
                st_d.cnt = '0;
            end else begin
                st_d.sh  = {st_q.sh[WORD_W-2:0], 1'b0};
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign msb_o  = st_q.sh[WORD_W-1];
    assign last_o = (st_q.cnt == LAST_BIT);
endmodule

// File: rtl/mser_out_ctrl.sv
module mser_out_ctrl
    import mser_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int QUART_FAST = 1,
    parameter int QUART_SLOW = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cnv_req_i,
    input  logic              read_during_i,
    input  logic              slow_sclk_i,
    input  logic              sclk_inv_i,
    input  logic              sync_inv_i,
    output logic              conv_start_o,
    input  logic              conv_done_i,
    input  logic [WORD_W-1:0] conv_word_i,
    output logic              busy_o,
    output logic              sclk_o,
    output logic              sync_o,
    output logic              sdout_o
);
    typedef struct packed {
        logic              busy;
        logic              go;
        logic              frame;
        rd_mode_e          mode;
        logic [WORD_W-1:0] last;
    } ctrl_t;

    ctrl_t             st_d, st_q;
    logic              accept, done_ok, load, frame_end;
    logic [WORD_W-1:0] load_word;
    logic              bit_end, last_bit, msb, sclk_raw;
    logic              frame_act, mode_during;

    always_comb begin
        accept    = cnv_req_i && !st_q.busy && !st_q.frame;
        done_ok   = conv_done_i && st_q.busy;
        load      = (accept && read_during_i) ||
                    (done_ok && (st_q.mode == RD_AFTER));
        load_word = accept ? st_q.last : conv_word_i;
        frame_end = bit_end && last_bit;

        st_d    = st_q;
        st_d.go = 1'b0;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.go   = 1'b1;
            st_d.mode = rd_mode_e'(read_during_i);
        end
        if (done_ok) begin
            st_d.last = conv_word_i;
            if (st_q.mode == RD_DURING) st_d.busy = 1'b0;
        end
        if (frame_end) begin
            st_d.frame = 1'b0;
            if (st_q.mode == RD_AFTER) st_d.busy = 1'b0;
        end
        if (load) st_d.frame = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    mser_bit_timer #(
        .QUART_FAST (QUART_FAST),
        .QUART_SLOW (QUART_SLOW)
    ) timer_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .run_i      (st_q.frame),
        .slow_i     (slow_sclk_i),
        .sclk_raw_o (sclk_raw),
        .bit_end_o  (bit_end)
    );

    mser_shifter #(
        .WORD_W (WORD_W)
    ) shift_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .word_i (load_word),
        .step_i (bit_end),
        .msb_o  (msb),
        .last_o (last_bit)
    );

    assign frame_act    = st_q.frame;
    assign mode_during  = (st_q.mode == RD_DURING);
    assign busy_o       = st_q.busy;
    assign conv_start_o = st_q.go;
    assign sync_o       = st_q.frame ^ sync_inv_i;
    assign sclk_o       = sclk_raw ^ sclk_inv_i;
    assign sdout_o      = st_q.frame & msb;
endmodule

// File: rtl/mser_out_chk.sv
module mser_out_chk #(
    parameter int WORD_W = 16
) (
    input logic clk_i,
    input logic rst_ni,
    input logic frame_act,
    input logic mode_during,
    input logic busy_o,
    input logic conv_start_o,
    input logic sclk_o,
    input logic sclk_inv_i,
    input logic sdout_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic             sclk_raw, raw_prev_q, frame_prev_q;
    logic [CNT_W-1:0] rise_cnt_q;

    assign sclk_raw = sclk_o ^ sclk_inv_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            raw_prev_q   <= 1'b0;
            frame_prev_q <= 1'b0;
            rise_cnt_q   <= '0;
        end else begin
            raw_prev_q   <= sclk_raw;
            frame_prev_q <= frame_act;
            if (!frame_act)                    rise_cnt_q <= '0;
            else if (sclk_raw && !raw_prev_q)  rise_cnt_q <= rise_cnt_q + 1'b1;
        end
    end

    // R1
    frame_pulses_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_prev_q && !frame_act) |-> (rise_cnt_q == CNT_W'(WORD_W)));

    // R3
    sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_act |-> (sclk_o == sclk_inv_i));

    // R4
    busy_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_act && !mode_during) |-> busy_o);

    // R4
    go_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        conv_start_o |=> !conv_start_o);

    // R6
    bit_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_act && frame_prev_q && (sclk_raw != raw_prev_q)) |-> $stable(sdout_o));

    // R7
    start_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> !conv_start_o);
endmodule

bind mser_out_ctrl mser_out_chk #(.WORD_W(WORD_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_act    (frame_act),
    .mode_during  (mode_during),
    .busy_o       (busy_o),
    .conv_start_o (conv_start_o),
    .sclk_o       (sclk_o),
    .sclk_inv_i   (sclk_inv_i),
    .sdout_o      (sdout_o)
);

// File: tb/mser_out_ctrl_tb_top.sv
module mser_out_ctrl_tb_top;
    localparam int LAT = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnv_req = 1'b0, rd_during = 1'b0, slow = 1'b0;
    logic        sclk_inv = 1'b0, sync_inv = 1'b0;
    logic        conv_start, conv_done = 1'b0;
    logic [15:0] conv_word = '0;
    logic        busy, sclk, sync, sdout;

    int n_chk = 0, n_fail = 0;
    int frames_done = 0, starts = 0, eng_cnt = 0, cyc = 0;
    logic [15:0] eng_word = '0, exp_word = '0, prev_word = '0, cap_word = '0;
    int nrise = 0, last_rise = 0;
    logic raw_p = 1'b0, act_p = 1'b0, cur_bit = 1'b0, busy_low_in = 1'b0;

    always #10 clk = ~clk;

    mser_out_ctrl dut_i (
        .clk_i (clk), .rst_ni (rst_n), .cnv_req_i (cnv_req),
        .read_during_i (rd_during), .slow_sclk_i (slow),
        .sclk_inv_i (sclk_inv), .sync_inv_i (sync_inv),
        .conv_start_o (conv_start), .conv_done_i (conv_done),
        .conv_word_i (conv_word), .busy_o (busy), .sclk_o (sclk),
        .sync_o (sync), .sdout_o (sdout)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // conversion engine model: fixed latency done pulse
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (rst_n && conv_start) begin
            starts++;
            eng_cnt = LAT;
        end else if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) begin
                conv_done = 1'b1;
                conv_word = eng_word;
            end
        end
    end

    // serial capture
    always @(negedge clk) begin
        logic raw, act;
        raw = sclk ^ sclk_inv;
        act = sync ^ sync_inv;
        if (rst_n) begin
            if (act && !act_p) begin
                nrise = 0; cap_word = '0; busy_low_in = 1'b0;
            end
            if (act) begin
                if (!busy) busy_low_in = 1'b1;
                if (raw && !raw_p) begin
                    // R5 rising edge spacing
                    if (nrise > 0) chk((cyc - last_rise) == (slow ? 8 : 4), "R5", cyc - last_rise, slow ? 8 : 4);
                    last_rise = cyc;
                    cur_bit = sdout;
                    cap_word = {cap_word[14:0], sdout};
                    nrise++;
                end
                if (!raw && raw_p) chk(sdout == cur_bit, "R6", sdout, cur_bit);
            end
            if (!act && act_p) begin
                chk(nrise == 16, "R1 pulses", nrise, 16);
                if (rd_during) begin
                    chk(cap_word == exp_word, "R8 word", cap_word, exp_word);
                    chk(busy_low_in, "R8 busy fell in frame", busy_low_in, 1);
                end else begin
                    chk(cap_word == exp_word, "R1 R4 word", cap_word, exp_word);
                    chk(!busy_low_in, "R4 busy held", busy_low_in, 0);
                    chk(busy == 1'b0, "R4 busy end", busy, 0);
                end
                frames_done++;
            end
            raw_p = raw;
            act_p = act;
        end
        cyc++;
    end

    task automatic do_conv(input logic [15:0] word);
        int f0, s0;
        f0 = frames_done;
        s0 = starts;
        eng_word = word;
        exp_word = rd_during ? prev_word : word;
        @(negedge clk) cnv_req = 1'b1;
        @(negedge clk) cnv_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R4 R8 busy high", busy, 1);
        cnv_req = 1'b1;
        @(negedge clk) cnv_req = 1'b0;
        while (frames_done == f0 || busy) @(posedge clk);
        repeat (2) @(negedge clk);
        chk((starts - s0) == 1, "R7 single start", starts - s0, 1);
        chk(sclk == sclk_inv, "R3 idle sclk", sclk, sclk_inv);
        chk(sync == sync_inv, "R2 idle sync", sync, sync_inv);
        prev_word = word;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R4 reset busy", busy, 0);
        chk(sclk == 1'b0, "R3 reset sclk", sclk, 0);
        chk(sync == 1'b0, "R2 reset sync", sync, 0);
        chk(sdout == 1'b0, "R1 reset sdout", sdout, 0);
        chk(conv_start == 1'b0, "R4 reset start", conv_start, 0);
        for (int cfg = 0; cfg < 16; cfg++) begin
            @(negedge clk);
            rd_during = cfg[0];
            slow      = cfg[1];
            sclk_inv  = cfg[2];
            sync_inv  = cfg[3];
            repeat (2) @(negedge clk);
            chk(sclk == sclk_inv, "R3 polarity", sclk, sclk_inv);
            chk(sync == sync_inv, "R2 polarity", sync, sync_inv);
            for (int k = 0; k < 3; k++) begin
                logic [15:0] w;
                w = (k == 1) ? 16'h8001 : (k == 2) ? 16'hFFFF
                    : 16'((cfg * 16'h9E37) ^ 16'h5A5A);
                do_conv(w);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule